// File: doc/BRIEF.md
# Banked GPIO Port Register Block

A memory-mapped general-purpose I/O controller that splits its pins into banks of eight lines. Each bank has a data register and a direction register on a simple 32-bit register bus with request, write enable, address, write data and byte strobes. Each pin gets an output-value signal and an output-enable signal. Each pin also has an input that is synchronized before it reaches the read path.

Bank `b` starts at address `(b+1)*8`. When that base reaches 0x90 it is moved up by 0x10, so the window 0x90–0x9F stays free for an interrupt controller that sits elsewhere. Inside a bank, the data register is at +0x0 and the direction register at +0x4. Software changes single pins with read-modify-write. The block has no set or clear aliases.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset every pin is an input (`pin_oe_o` all zero), every `pin_out_o` bit is zero, and `rdata_o` is zero.
- R2: Bank `b` has base `(b+1)*8`, plus 0x10 when that value is 0x90 or more. Its data register is at base+0x0 and its direction register at base+0x4. Pin `n` is bank `n/8`, bit `n%8` of both registers.
- R3: A direction bit of 1 makes the pin an input (`pin_oe_o` low). A direction bit of 0 makes it an output (`pin_oe_o` high). A write shows on `pin_oe_o` after the clock edge that samples it.
- R4: A write to a data register shows on the bank's `pin_out_o` bits after the clock edge that samples the write.
- R5: A data-register read returns, for each bit, the synchronized `pin_in_i` value when the pin is an input and the driven value when it is an output. A pin change made before edge E1 is first returned by a read sampled at edge E3.
- R6: A read sampled at a clock edge puts its value on `rdata_o` after that edge. `rdata_o` keeps that value until the next read.
- R7: Addresses 0x90–0x9F, any address that is not word aligned, and any address that is not a bank register read as zero. Writes to them change nothing.
- R8: Bits 31:8 of every register read as zero and ignore writes. A write with `be_i[0]` low changes nothing.
- R9: Reading a direction register returns the last value written to it. The reset value is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte strobes |
| rdata_o | output | 32 | Registered read data |
| pin_in_i | input | NUM_BANKS*8 | Raw pin inputs |
| pin_out_o | output | NUM_BANKS*8 | Pin output values |
| pin_oe_o | output | NUM_BANKS*8 | Pin output enables |

## Verification
Writes show on `pin_out_o` and `pin_oe_o` in the cycle after the sampling edge. The bench samples these outputs at the falling edge that follows. Read data is registered at the edge that samples the request and is checked at the next falling edge. For a synchronized input, the bench changes the pin and then issues three reads in a row. It expects the old value from the first two reads and the new value from the third, which checks the two-flop delay exactly. The hole and unmapped accesses are checked in the same way: the pin outputs must stay unchanged and the read must return zero.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int LANES      = 8;
  localparam int HOLE_LO    = 'h90;
  localparam int HOLE_HI    = 'h9F;
  localparam int HOLE_SKIP  = 'h10;
  localparam int DIR_OFS    = 'h4;

  // bank register base, stepping over the interrupt window
  function automatic int bank_base(input int b);
    int base;
    base = (b + 1) * 8;
    if (base >= HOLE_LO) base = base + HOLE_SKIP;
    return base;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 20,
  parameter int ADDR_W    = 8
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [NUM_BANKS-1:0] hit_data_o,
  output logic [NUM_BANKS-1:0] hit_dir_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int BASE = bank_base(b);
    assign hit_data_o[b] = (addr_i == ADDR_W'(BASE));
    assign hit_dir_o[b]  = (addr_i == ADDR_W'(BASE + DIR_OFS));
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_data_i,
  input  logic          wr_dir_i,
  input  logic [LW-1:0] wdata_i,
  input  logic [LW-1:0] sync_in_i,
  output logic [LW-1:0] data_q_o,
  output logic [LW-1:0] dir_q_o,
  output logic [LW-1:0] rd_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q_o <= '0;
      dir_q_o  <= '1;  // all inputs
    end else begin
      if (wr_data_i) data_q_o <= wdata_i;
      if (wr_dir_i)  dir_q_o  <= wdata_i;
    end
  end

  // inputs report the pin, outputs report the driven value
  for (genvar i = 0; i < LW; i++) begin : g_bit
    assign rd_data_o[i] = dir_q_o[i] ? sync_in_i[i] : data_q_o[i];
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 20,
  parameter int ADDR_W    = 8,
  localparam int NPINS    = NUM_BANKS * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [3:0]        be_i,
  output logic [31:0]       rdata_o,
  input  logic [NPINS-1:0]  pin_in_i,
  output logic [NPINS-1:0]  pin_out_o,
  output logic [NPINS-1:0]  pin_oe_o
);
  logic [NUM_BANKS-1:0] hit_data, hit_dir;
  logic [NPINS-1:0]     sync_in, data_q, dir_q, bank_rd;
  logic                 wr_ok, rd_ok;
  logic [LANES-1:0]     rd_mux;
  logic                 unused_bits;

  assign unused_bits = ^{wdata_i[31:LANES], be_i[3:1]};
  assign wr_ok = req_i & we_i & be_i[0];
  assign rd_ok = req_i & ~we_i;

  gpio_addr_dec #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) i_dec (
    .addr_i    (addr_i),
    .hit_data_o(hit_data),
    .hit_dir_o (hit_dir)
  );

  gpio_sync #(.W(NPINS)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_in_i),
    .q_o   (sync_in)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_bank #(.LW(LANES)) i_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_data_i(wr_ok & hit_data[b]),
      .wr_dir_i (wr_ok & hit_dir[b]),
      .wdata_i  (wdata_i[LANES-1:0]),
      .sync_in_i(sync_in[b*LANES +: LANES]),
      .data_q_o (data_q[b*LANES +: LANES]),
      .dir_q_o  (dir_q[b*LANES +: LANES]),
      .rd_data_o(bank_rd[b*LANES +: LANES])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (hit_data[b]) rd_mux = rd_mux | bank_rd[b*LANES +: LANES];
      if (hit_dir[b])  rd_mux = rd_mux | dir_q[b*LANES +: LANES];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= '0;
    else if (rd_ok) rdata_o <= {{(32-LANES){1'b0}}, rd_mux};
  end

  assign pin_out_o = data_q;
  assign pin_oe_o  = ~dir_q;
endmodule

// File: rtl/gpio_bank_regs_chk.sv
module gpio_bank_regs_chk
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 20,
  parameter int ADDR_W    = 8,
  localparam int NPINS    = NUM_BANKS * LANES
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [3:0]        be_i,
  input logic [31:0]       rdata_o,
  input logic [NPINS-1:0]  pin_out_o,
  input logic [NPINS-1:0]  pin_oe_o
);
  logic in_hole;
  assign in_hole = (int'(addr_i) >= HOLE_LO) && (int'(addr_i) <= HOLE_HI);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int BASE = bank_base(b);

    AST_DIR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && we_i && be_i[0] && addr_i == ADDR_W'(BASE + DIR_OFS))
      |=> pin_oe_o[b*LANES +: LANES] == ~$past(wdata_i[LANES-1:0])); // R3

    AST_DATA_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && we_i && be_i[0] && addr_i == ADDR_W'(BASE))
      |=> pin_out_o[b*LANES +: LANES] == $past(wdata_i[LANES-1:0])); // R4
  end

  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && be_i[0]) |=> ($stable(pin_out_o) && $stable(pin_oe_o))); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o)); // R6

  AST_HOLE_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && in_hole) |=> rdata_o == 32'h0); // R7

  AST_HOLE_WRITE_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && in_hole) |=> ($stable(pin_out_o) && $stable(pin_oe_o))); // R7

  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[31:LANES] == '0); // R8
endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .be_i     (be_i),
  .rdata_o  (rdata_o),
  .pin_out_o(pin_out_o),
  .pin_oe_o (pin_oe_o)
);

// File: tb/test_gpio_bank_regs.sv
`timescale 1ns/1ps
module test_gpio_bank_regs;
  localparam int NB    = 20;
  localparam int AW    = 8;
  localparam int NP    = NB * 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0;
  logic          we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic [3:0]    be_i = '0;
  logic [31:0]   rdata_o;
  logic [NP-1:0] pin_in_i = '0;
  logic [NP-1:0] pin_out_o;
  logic [NP-1:0] pin_oe_o;

  int n_tests = 0;
  int n_fail  = 0;

  logic [NP-1:0] exp_out = '0;
  logic [NP-1:0] exp_oe  = '0;

  always #10 clk_i = ~clk_i;

  gpio_bank_regs #(.NUM_BANKS(NB), .ADDR_W(AW)) i_gpio_bank_regs (.*);

  // expected map, written from the requirement
  function automatic int base_of(input int b);
    int a;
    a = (b + 1) * 8;
    if (a >= 'h90) a += 'h10;
    return a;
  endfunction

  task automatic check(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = AW'(a); wdata_i = d; be_i = be;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_read(input int a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = AW'(a);
    @(negedge clk_i);
    req_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic t_reset;
    check("R1 oe", pin_oe_o, '0);
    check("R1 out", pin_out_o, '0);
    check("R1 rdata", NP'(rdata_o), '0);
  endtask

  task automatic t_map;
    logic [31:0] r;
    foreach (exp_oe[i]) exp_oe[i] = 1'b0;
    for (int b = 0; b < NB; b++) begin
      bus_write(base_of(b) + 4, 32'h0000_0000 | (b + 1), 4'h1);
      exp_oe[b*8 +: 8] = ~8'(b + 1);
      check("R2 R3 dir map", pin_oe_o, exp_oe);
    end
    bus_read(base_of(17) + 4, r);
    check("R9 dir readback", NP'(r), NP'(32'd18));
    for (int b = 0; b < NB; b++) begin
      bus_write(base_of(b) + 4, 32'hFF, 4'h1);
      exp_oe[b*8 +: 8] = 8'h00;
    end
    check("R3 all inputs", pin_oe_o, exp_oe);
  endtask

  task automatic t_data;
    logic [31:0] r;
    bus_write(base_of(16), 32'hA5, 4'h1);
    exp_out[16*8 +: 8] = 8'hA5;
    check("R4 bank16", pin_out_o, exp_out);
    bus_write(base_of(17), 32'h3C, 4'h1);
    exp_out[17*8 +: 8] = 8'h3C;
    check("R4 bank17", pin_out_o, exp_out);
    bus_write(base_of(0), 32'h81, 4'h1);
    exp_out[7:0] = 8'h81;
    check("R4 bank0", pin_out_o, exp_out);
    // mix: low nibble outputs, high nibble inputs
    pin_in_i[16*8 +: 8] = 8'h50;
    bus_write(base_of(16) + 4, 32'hF0, 4'h1);
    exp_oe[16*8 +: 8] = 8'h0F;
    repeat (3) @(negedge clk_i);
    bus_read(base_of(16), r);
    check("R5 mixed", NP'(r), NP'(32'h55));
  endtask

  task automatic t_sync;
    logic [31:0] r1, r2, r3;
    pin_in_i[3*8 +: 8] = 8'h00;
    repeat (3) @(negedge clk_i);
    pin_in_i[3*8 +: 8] = 8'hC3;
    req_i = 1'b1; we_i = 1'b0; addr_i = AW'(base_of(3));
    @(negedge clk_i); r1 = rdata_o;
    @(negedge clk_i); r2 = rdata_o;
    @(negedge clk_i); r3 = rdata_o;
    req_i = 1'b0;
    check("R5 sync E1", NP'(r1), '0);
    check("R5 sync E2", NP'(r2), '0);
    check("R5 sync E3", NP'(r3), NP'(32'hC3));
    repeat (2) @(negedge clk_i);
    check("R6 hold", NP'(rdata_o), NP'(32'hC3));
  endtask

  task automatic t_hole;
    logic [31:0] r;
    for (int a = 'h90; a <= 'h9C; a += 4) begin
      bus_write(a, 32'h0, 4'hF);
      check("R7 hole write", pin_oe_o, exp_oe);
      check("R7 hole write out", pin_out_o, exp_out);
    end
    pin_in_i = '1;
    repeat (3) @(negedge clk_i);
    bus_read('h94, r);
    check("R7 hole read", NP'(r), '0);
    bus_read('h00, r);
    check("R7 addr0 read", NP'(r), '0);
    bus_read('h09, r);
    check("R7 misaligned read", NP'(r), '0);
    bus_write('h04, 32'h0, 4'hF);
    bus_write('h0C - 1, 32'h0, 4'hF);
    bus_write('hF0, 32'h0, 4'hF);
    check("R7 unmapped write", pin_oe_o, exp_oe);
    bus_read(base_of(5), r);
    check("R7 bank5 reads pins", NP'(r), NP'(32'hFF));
  endtask

  task automatic t_upper;
    logic [31:0] r;
    bus_write(base_of(2) + 4, 32'h0, 4'h1);
    exp_oe[2*8 +: 8] = 8'hFF;
    bus_write(base_of(2), 32'hFFFF_FF5A, 4'hF);
    exp_out[2*8 +: 8] = 8'h5A;
    check("R8 out", pin_out_o, exp_out);
    bus_read(base_of(2), r);
    check("R8 upper zero", NP'(r), NP'(32'h5A));
    bus_write(base_of(2), 32'h0000_0011, 4'hE);
    check("R8 be0 low", pin_out_o, exp_out);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_map;
    t_data;
    t_sync;
    t_hole;
    t_upper;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule